// File: doc/BRIEF.md
# Video Timing Control and Status Registers

This block is the byte-wide register front end of a simple raster video generator. A host writes a control byte that enables vertical interrupts, picture output, sync timing and cursor comparison, and that picks a crystal source and a pixel clock divisor. The block turns the divisor code into a single-cycle pixel clock enable. It gates the blanking and sync signals that come back from the raster counters, and it latches a pending interrupt when vertical blanking begins. It also holds two cursor position bytes and twelve timing parameter bytes, and drives all of them to the raster logic as plain outputs.

A status byte reports the pending interrupt together with a monitor sense code and a board identity code. Both codes are sampled from input pins and cannot be written. The host clears the pending flag by writing a one to its bit. Writes take effect on the clock edge where `wr_en` is high. A read is requested by raising `rd_en` for one cycle, and the result comes back one cycle later with `rd_valid`. The host always accepts read results, so this path has no back-pressure and no ready signal. Every other pin is plain level control or status.

Top module: `vid_timing_ctl`

## Requirements
- R1: After reset the control byte reads 0x00, `irq` and `pix_ce` are low, `hsync_out` and `vsync_out` are low, and `blank_out` is high.
- R2: A read issued with `rd_en` returns its byte on `rd_data` one cycle later, with `rd_valid` high for exactly that cycle. Offsets 0x12 (cursor start), 0x13 (cursor end) and 0x14 to 0x1F (timing bytes 0 to 11) are read/write. Timing byte i drives `timing_cfg[8i+7:8i]`. Unmapped offsets read 0x00.
- R3: The control byte at offset 0x10 reads back what was written. Bit 4 drives `cursor_en` and bits 3:2 drive `xtal_sel`.
- R4: The status byte at offset 0x11 reads {pending, sense[2:0], id[3:0]}, with bit 7 the pending flag, bits 6:4 from `sense_in` and bits 3:0 from `id_in` (1 color, 2 mono, 3 mono ECL). Writes to bits 6:0 are ignored.
- R5: While control bit 5 (timing enable) is set, `pix_ce` pulses for one cycle every N clocks, where N is 1, 2, 3 or 4 for control bits 1:0 equal to 0, 1, 2 or 3.
- R6: A control write that changes the divisor code restarts the divider, so `pix_ce` is high in the first cycle after the write.
- R7: With timing enable clear, `pix_ce`, `hsync_out` and `vsync_out` stay low and `blank_out` stays high.
- R8: With timing enable set and control bit 6 (video enable) clear, `blank_out` is high and the sync outputs follow `hsync_in` and `vsync_in`.
- R9: With both enables set, `blank_out` follows `blank_in` and the syncs follow their inputs.
- R10: A rising edge on `vblank_in` sets the pending flag when control bit 7 (interrupt enable) is set. With interrupt enable clear, the flag does not set.
- R11: A status write with bit 7 set clears the pending flag. A new vertical blank in the same cycle wins over the clear. A status write with bit 7 clear leaves the flag unchanged.
- R12: `irq` is the pending flag ANDed with interrupt enable. Clearing interrupt enable masks `irq` but keeps the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| addr | input | 6 | Byte offset for read or write |
| wr_data | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| sense_in | input | 3 | Monitor sense code pins |
| id_in | input | 4 | Board identity pins |
| vblank_in | input | 1 | Vertical blanking level from the raster counters |
| blank_in | input | 1 | Composite blanking from the raster counters |
| hsync_in | input | 1 | Horizontal sync from the raster counters |
| vsync_in | input | 1 | Vertical sync from the raster counters |
| pix_ce | output | 1 | Pixel clock enable pulse |
| blank_out | output | 1 | Gated blanking |
| hsync_out | output | 1 | Gated horizontal sync |
| vsync_out | output | 1 | Gated vertical sync |
| irq | output | 1 | Vertical interrupt request |
| cursor_en | output | 1 | Cursor compare enable |
| xtal_sel | output | 2 | Crystal source select |
| cursor_start | output | 8 | Cursor start byte |
| cursor_end | output | 8 | Cursor end byte |
| timing_cfg | output | 96 | Twelve timing parameter bytes |

## Verification
A divider counter left stale across a code change shows up in the first cycle after the control write: `pix_ce` is low there when it should be high, and the number of pulses in the next twelve clocks is wrong. A pending flag that sets, clears or holds at the wrong time appears at `irq` one cycle after the `vblank_in` edge or the status write, and in the next status read. Gating faults are visible at once at `blank_out` and the sync pins for each enable combination. A register decode slip shows up in the read-back byte or in the `timing_cfg` slice.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int OFS_CTRL  = 'h10;
  localparam int OFS_STAT  = 'h11;
  localparam int OFS_CURS  = 'h12;
  localparam int OFS_CURE  = 'h13;
  localparam int OFS_TIME  = 'h14;
  localparam int SENSE_W   = 3;
  localparam int ID_W      = 4;

  typedef struct packed {
    logic       ien;
    logic       ven;
    logic       ten;
    logic       cen;
    logic [1:0] xtal;
    logic [1:0] div;
  } ctrl_t;
endpackage

// File: rtl/vcr_clkdiv.sv
module vcr_clkdiv #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              ce
);
  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || restart)  cnt_q <= '0;
    else if (cnt_q == code)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign ce = run && (cnt_q == '0);

  // R5
  ce_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && code != '0 && !restart) |=> !ce);
  // R6
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && run) |=> ce);
endmodule

// File: rtl/vcr_vint.sv
module vcr_vint (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_in,
  input  logic ien,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic set;

  assign set = vblank_in && !prev_q && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= vblank_in;
      if (set)      pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  // R10
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend);
  // R11
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pend);
  // R11
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(pend));
endmodule

// File: rtl/vcr_regfile.sv
module vcr_regfile
  import vcr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NTIME  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               wr_data,
  input  logic [SENSE_W+ID_W-1:0]  stat_pins,
  input  logic                     pend,
  output ctrl_t                    ctrl,
  output logic [7:0]               cur_start,
  output logic [7:0]               cur_end,
  output logic [8*NTIME-1:0]       timing,
  output logic                     stat_clr,
  output logic                     div_restart,
  output logic                     rd_valid,
  output logic [7:0]               rd_data
);
  localparam int TIME_END = OFS_TIME + NTIME;

  logic [SENSE_W+ID_W-1:0] stat_q;
  logic [7:0]              tim_q [NTIME];
  logic [7:0]              rd_next;
  int                      a_int;
  logic                    hit_ctrl, hit_stat, hit_curs, hit_cure;

  assign a_int    = int'(addr);
  assign hit_ctrl = (a_int == OFS_CTRL);
  assign hit_stat = (a_int == OFS_STAT);
  assign hit_curs = (a_int == OFS_CURS);
  assign hit_cure = (a_int == OFS_CURE);

  assign stat_clr    = wr_en && hit_stat && wr_data[7];
  assign div_restart = wr_en && hit_ctrl && (wr_data[1:0] != ctrl.div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      cur_start <= '0;
      cur_end   <= '0;
      stat_q    <= '0;
    end else begin
      stat_q <= stat_pins;
      if (wr_en && hit_ctrl) ctrl      <= ctrl_t'(wr_data);
      if (wr_en && hit_curs) cur_start <= wr_data;
      if (wr_en && hit_cure) cur_end   <= wr_data;
    end
  end

  for (genvar g = 0; g < NTIME; g++) begin : g_time
    always_ff @(posedge clk) begin
      if (!rst_n)                                  tim_q[g] <= '0;
      else if (wr_en && a_int == OFS_TIME + g)     tim_q[g] <= wr_data;
    end
    assign timing[8*g +: 8] = tim_q[g];
  end

  always_comb begin
    rd_next = '0;
    if (hit_ctrl)      rd_next = ctrl;
    else if (hit_stat) rd_next = {pend, stat_q};
    else if (hit_curs) rd_next = cur_start;
    else if (hit_cure) rd_next = cur_end;
    else begin
      for (int i = 0; i < NTIME; i++)
        if (a_int == OFS_TIME + i) rd_next = tim_q[i];
    end
    if (a_int >= TIME_END) rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R2
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/vid_timing_ctl.sv
module vid_timing_ctl
  import vcr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NTIME  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wr_data,
  output logic                 rd_valid,
  output logic [7:0]           rd_data,
  input  logic [SENSE_W-1:0]   sense_in,
  input  logic [ID_W-1:0]      id_in,
  input  logic                 vblank_in,
  input  logic                 blank_in,
  input  logic                 hsync_in,
  input  logic                 vsync_in,
  output logic                 pix_ce,
  output logic                 blank_out,
  output logic                 hsync_out,
  output logic                 vsync_out,
  output logic                 irq,
  output logic                 cursor_en,
  output logic [1:0]           xtal_sel,
  output logic [7:0]           cursor_start,
  output logic [7:0]           cursor_end,
  output logic [8*NTIME-1:0]   timing_cfg
);
  ctrl_t ctrl;
  logic  pend;
  logic  stat_clr;
  logic  div_restart;

  vcr_regfile #(.ADDR_W(ADDR_W), .NTIME(NTIME)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .stat_pins({sense_in, id_in}), .pend(pend),
    .ctrl(ctrl), .cur_start(cursor_start), .cur_end(cursor_end),
    .timing(timing_cfg), .stat_clr(stat_clr), .div_restart(div_restart),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  vcr_clkdiv #(.CODE_W(2)) u_div (
    .clk(clk), .rst_n(rst_n), .run(ctrl.ten), .code(ctrl.div),
    .restart(div_restart), .ce(pix_ce)
  );

  vcr_vint u_vint (
    .clk(clk), .rst_n(rst_n), .vblank_in(vblank_in), .ien(ctrl.ien),
    .clr(stat_clr), .pend(pend)
  );

  assign blank_out = blank_in || !(ctrl.ven && ctrl.ten);
  assign hsync_out = hsync_in && ctrl.ten;
  assign vsync_out = vsync_in && ctrl.ten;
  assign irq       = pend && ctrl.ien;
  assign cursor_en = ctrl.cen;
  assign xtal_sel  = ctrl.xtal;

  // R3
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == OFS_CTRL) |=> (ctrl == $past(wr_data)));
  // R7
  stopped_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.ten) |-> !pix_ce);
endmodule

// File: tb/tb_vid_timing_ctl.sv
module tb_vid_timing_ctl;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [5:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic [2:0] sense_in = 3'b101;
  logic [3:0] id_in = 4'h1;
  logic vblank_in = 0, blank_in = 0, hsync_in = 1, vsync_in = 1;
  logic pix_ce, blank_out, hsync_out, vsync_out, irq, cursor_en;
  logic [1:0] xtal_sel;
  logic [7:0] cursor_start, cursor_end;
  logic [95:0] timing_cfg;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  vid_timing_ctl dut (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = 6'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, int e, string req);
    @(negedge clk); exp_q.push_back(8'(e)); tag_q.push_back(req);
    rd_en = 1; addr = 6'(a);
    @(negedge clk); rd_en = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected rd_valid", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic measure(int exp_n, string req);
    int c = 0;
    chk(pix_ce == 1, {req, " first cycle"}, pix_ce, 1);
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      c += pix_ce;
    end
    chk(c == exp_n, {req, " pulse count"}, c, exp_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(blank_out == 1, "R1 blank", blank_out, 1);
    chk(hsync_out == 0 && vsync_out == 0, "R1 sync", hsync_out, 0);
    chk(pix_ce == 0, "R1 pix_ce", pix_ce, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rd('h10, 'h00, "R1 ctrl reset");
    // R2
    wr('h12, 'hA5); wr('h13, 'h3C);
    rd('h12, 'hA5, "R2 cursor start"); rd('h13, 'h3C, "R2 cursor end");
    chk(cursor_start == 8'hA5 && cursor_end == 8'h3C, "R2 cursor pins", cursor_start, 'hA5);
    for (int i = 0; i < 12; i++) wr('h14 + i, i * 17 + 3);
    for (int i = 0; i < 12; i++) begin
      rd('h14 + i, 8'(i * 17 + 3), "R2 timing byte");
      chk(timing_cfg[8*i +: 8] == 8'(i * 17 + 3), "R2 timing_cfg", timing_cfg[8*i +: 8], i * 17 + 3);
    end
    rd('h05, 'h00, "R2 unmapped low"); rd('h20, 'h00, "R2 unmapped high");
    // R3 / R7
    wr('h10, 'h1C);
    chk(cursor_en == 1 && xtal_sel == 2'd3, "R3 cursor/xtal", {cursor_en, xtal_sel}, 'h7);
    rd('h10, 'h1C, "R3 ctrl readback");
    chk(pix_ce == 0 && hsync_out == 0 && vsync_out == 0 && blank_out == 1, "R7 stopped", {pix_ce, hsync_out, blank_out}, 1);
    // R4
    rd('h11, 'h51, "R4 status");
    wr('h11, 'h7F);
    rd('h11, 'h51, "R4 status write ignored");
    sense_in = 3'b010; id_in = 4'h3;
    rd('h11, 'h23, "R4 status pins");
    // R5 / R6
    wr('h10, 'h20); measure(12, "R5 div1");
    wr('h10, 'h21); measure(6, "R6 R5 div2");
    wr('h10, 'h22); measure(4, "R6 R5 div3");
    wr('h10, 'h23); measure(3, "R6 R5 div4");
    // R8
    chk(blank_out == 1 && hsync_out == 1 && vsync_out == 1, "R8 video off", {blank_out, hsync_out, vsync_out}, 7);
    // R9
    wr('h10, 'h60);
    chk(blank_out == 0 && hsync_out == 1, "R9 both on", {blank_out, hsync_out}, 1);
    blank_in = 1; hsync_in = 0; @(negedge clk);
    chk(blank_out == 1 && hsync_out == 0, "R9 follow", {blank_out, hsync_out}, 2);
    // R10 not set when disabled
    vblank_in = 1; @(negedge clk); @(negedge clk);
    rd('h11, 'h23, "R10 no set while disabled");
    vblank_in = 0;
    wr('h10, 'hE0);
    vblank_in = 1; @(negedge clk);
    chk(irq == 1, "R10 R12 irq set", irq, 1);
    rd('h11, 'hA3, "R10 pending");
    // R12
    wr('h10, 'h60);
    chk(irq == 0, "R12 masked", irq, 0);
    rd('h11, 'hA3, "R12 flag kept");
    wr('h10, 'hE0);
    chk(irq == 1, "R12 unmasked", irq, 1);
    // R11
    wr('h11, 'h00);
    rd('h11, 'hA3, "R11 bit7 zero no clear");
    wr('h11, 'h80);
    chk(irq == 0, "R11 cleared irq", irq, 0);
    rd('h11, 'h23, "R11 cleared");
    vblank_in = 0; @(negedge clk);
    vblank_in = 1; wr_en = 1; addr = 6'h11; wr_data = 8'h80;
    @(negedge clk); wr_en = 0;
    chk(irq == 1, "R11 set wins", irq, 1);
    rd('h11, 'hA3, "R11 set wins status");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 reads drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule